// File: doc/BRIEF.md
# Multi-channel compare-match timer

This block is a memory-mapped timer with several independent 32-bit compare-match channels. All channels share one run register. Each bit of that register starts or stops one channel. Each channel has three registers: a control/status word, a count register and a compare register. Counting is paced by a slow reference tick, which arrives as a one-cycle enable on the system clock, and each channel divides that tick by a prescale code.

When a channel's count equals its compare value on a count tick, the channel sets a sticky match flag and clears its counter. It then either keeps counting (repeat mode) or clears its own run bit (single shot). If the counter passes all ones without a match, a sticky overflow flag is raised instead.

The match flag can drive a level interrupt line or a DMA request line, chosen by a routing field in the control word. A value written to the count register takes effect only after a short synchronisation delay measured in reference ticks.

Top module: `match_timer`

## Requirements
- R1: After reset, the run register reads 0. Every control word reads 0, every count reads 0 and every compare reads 0xFFFFFFFF. All interrupt and DMA outputs are low.
- R2: The run register is at byte address 0x00. Channel n's registers start at 0x10 + 16*n: the control word at +0x0, the count at +0x4 and the compare at +0x8. Any other word reads as 0.
- R3: Bit n of the run register enables counting for channel n only. A stopped channel holds its count. Starting or stopping one channel does not disturb the count of any other channel.
- R4: Control bits [2:0] select the count rate from the reference tick: code 4 counts every 8 ticks, 5 every 32, 6 every 128 and 7 every tick. Codes 0 to 3 act like code 4. A channel's prescaler restarts from zero whenever the channel is stopped.
- R5: On a count tick where the count equals the compare value, the counter goes to 0 and match flag bit 15 sets. A full period is therefore compare+1 count ticks.
- R6: With repeat bit 8 set, the channel keeps running after a match. With it clear, the match also clears the channel's run bit, and the count stays at 0.
- R7: On a count tick where the count is 0xFFFFFFFF and does not equal the compare value, the counter wraps to 0 and overflow flag bit 14 sets.
- R8: Writing 0 to bit 15 or bit 14 clears that flag. Writing 1 to either bit leaves it unchanged, so software cannot set a flag.
- R9: irq_o[n] is high when the match flag, enable bit 7 and route field bits [5:4] = 2 are all present. dma_o[n] is high under the same condition with route = 1. Route 0 drives neither. Both outputs are registered and follow the control word one cycle later, so writing 0 to the control word drops them.
- R10: A write to a count register takes effect on the second reference tick after the write. Until then, reads return the old value and the channel keeps counting from the old value. The tick that loads the new value does not also count.
- R11: Read data appears on bus_rdata in the cycle after bus_rd and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| slow_tick | input | 1 | One-cycle enable marking a reference clock tick |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| irq_o | output | NUM_CH | Per-channel level interrupt request |
| dma_o | output | NUM_CH | Per-channel DMA request |

## Verification
The assertions check these rules on every cycle:
- A stopped channel with no count load pending keeps its count.
- A match flag rises only from a count equal to the compare value, and the counter is then 0.
- An overflow flag rises only from an all-ones count.
- A single-shot match clears the run bit.
- A count write always leaves a load pending.
- Interrupt and DMA requests are never raised together.

Only the bench scenarios can show the rest:
- the absolute division ratios of each prescale code;
- the exact tick on which a delayed count load lands;
- that one channel's run bit leaves another channel's count undisturbed;
- the register map as seen through reads.

// File: rtl/mt_pkg.sv
package mt_pkg;
  localparam int REG_W        = 32;
  localparam int MATCH_BIT    = 15;
  localparam int OVF_BIT      = 14;
  localparam int REPEAT_BIT   = 8;
  localparam int IE_BIT       = 7;
  localparam int ROUTE_LO     = 4;
  localparam int PRE_W        = 7;
  localparam logic [1:0] ROUTE_DMA = 2'd1;
  localparam logic [1:0] ROUTE_IRQ = 2'd2;

  typedef struct packed {
    logic       flag_m;
    logic       flag_o;
    logic       repeat_en;
    logic       ie;
    logic [1:0] route;
    logic [2:0] sel;
  } ctrl_t;

  function automatic logic [PRE_W-1:0] div_limit(input logic [2:0] sel);
    case (sel)
      3'd5:    div_limit = PRE_W'(31);
      3'd6:    div_limit = PRE_W'(127);
      3'd7:    div_limit = '0;
      default: div_limit = PRE_W'(7);
    endcase
  endfunction

  function automatic logic [REG_W-1:0] pack_ctrl(input ctrl_t c);
    logic [REG_W-1:0] w;
    w = '0;
    w[MATCH_BIT]            = c.flag_m;
    w[OVF_BIT]              = c.flag_o;
    w[REPEAT_BIT]           = c.repeat_en;
    w[IE_BIT]               = c.ie;
    w[ROUTE_LO+1:ROUTE_LO]  = c.route;
    w[2:0]                  = c.sel;
    return w;
  endfunction
endpackage

// File: rtl/mt_prescaler.sv
module mt_prescaler
  import mt_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic       slow_tick,
  input  logic [2:0] sel,
  output logic       cnt_tick
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] lim;

  assign lim      = div_limit(sel);
  assign cnt_tick = run & slow_tick & (pre_q >= lim);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      pre_q <= '0;
    end else if (slow_tick) begin
      pre_q <= (pre_q >= lim) ? '0 : pre_q + 1'b1;
    end
  end
endmodule

// File: rtl/mt_count_sync.sv
module mt_count_sync #(
  parameter int W          = 32,
  parameter int SYNC_TICKS = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         slow_tick,
  output logic         load,
  output logic [W-1:0] load_val,
  output logic         pending
);
  localparam int REM_W = $clog2(SYNC_TICKS + 1);

  logic [REM_W-1:0] rem_q;

  assign load = pending & slow_tick & (rem_q == REM_W'(1)) & ~wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending  <= 1'b0;
      rem_q    <= '0;
      load_val <= '0;
    end else if (wr) begin
      pending  <= 1'b1;
      rem_q    <= REM_W'(SYNC_TICKS);
      load_val <= wdata;
    end else if (pending && slow_tick) begin
      if (rem_q == REM_W'(1)) pending <= 1'b0;
      rem_q <= rem_q - 1'b1;
    end
  end
endmodule

// File: rtl/mt_channel.sv
module mt_channel
  import mt_pkg::*;
#(
  parameter int W          = 32,
  parameter int SYNC_TICKS = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             slow_tick,
  input  logic             ctrl_we,
  input  logic             cnt_we,
  input  logic             cmp_we,
  input  logic [W-1:0]     wdata,
  output logic [REG_W-1:0] ctrl_rd,
  output logic [W-1:0]     cnt_o,
  output logic [W-1:0]     cmp_o,
  output logic             irq_o,
  output logic             dma_o,
  output logic             done_o,
  output logic             flag_m_o,
  output logic             flag_o_o,
  output logic             repeat_o,
  output logic             pend_o
);
  ctrl_t        ctrl_q;
  logic [W-1:0] cnt_q;
  logic [W-1:0] cmp_q;
  logic         cnt_tick;
  logic         load;
  logic [W-1:0] load_val;
  logic         hit;
  logic         wrap;

  mt_prescaler u_pre (
    .clk(clk), .rst(rst), .run(run), .slow_tick(slow_tick),
    .sel(ctrl_q.sel), .cnt_tick(cnt_tick)
  );

  mt_count_sync #(.W(W), .SYNC_TICKS(SYNC_TICKS)) u_sync (
    .clk(clk), .rst(rst), .wr(cnt_we), .wdata(wdata), .slow_tick(slow_tick),
    .load(load), .load_val(load_val), .pending(pend_o)
  );

  assign hit  = cnt_tick & ~load & (cnt_q == cmp_q);
  assign wrap = cnt_tick & ~load & ~hit & (cnt_q == {W{1'b1}});

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (ctrl_we) begin
      ctrl_q.flag_m    <= (ctrl_q.flag_m & wdata[MATCH_BIT]) | hit;
      ctrl_q.flag_o    <= (ctrl_q.flag_o & wdata[OVF_BIT]) | wrap;
      ctrl_q.repeat_en <= wdata[REPEAT_BIT];
      ctrl_q.ie        <= wdata[IE_BIT];
      ctrl_q.route     <= wdata[ROUTE_LO+1:ROUTE_LO];
      ctrl_q.sel       <= wdata[2:0];
    end else begin
      ctrl_q.flag_m <= ctrl_q.flag_m | hit;
      ctrl_q.flag_o <= ctrl_q.flag_o | wrap;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_tick) begin
      cnt_q <= (hit || wrap) ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cmp_q <= '1;
    else if (cmp_we) cmp_q <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o <= 1'b0;
      dma_o <= 1'b0;
    end else begin
      irq_o <= ctrl_q.flag_m & ctrl_q.ie & (ctrl_q.route == ROUTE_IRQ);
      dma_o <= ctrl_q.flag_m & ctrl_q.ie & (ctrl_q.route == ROUTE_DMA);
    end
  end

  assign done_o   = hit & ~ctrl_q.repeat_en;
  assign ctrl_rd  = pack_ctrl(ctrl_q);
  assign cnt_o    = cnt_q;
  assign cmp_o    = cmp_q;
  assign flag_m_o = ctrl_q.flag_m;
  assign flag_o_o = ctrl_q.flag_o;
  assign repeat_o = ctrl_q.repeat_en;
endmodule

// File: rtl/match_timer.sv
module match_timer #(
  parameter int NUM_CH     = 4,
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  parameter int SYNC_TICKS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              slow_tick,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NUM_CH-1:0] irq_o,
  output logic [NUM_CH-1:0] dma_o
);
  localparam int BLK_W = ADDR_W - 4;

  logic [NUM_CH-1:0]             run_q;
  logic [NUM_CH-1:0]             hit_ch;
  logic [NUM_CH-1:0]             done_w;
  logic [NUM_CH-1:0]             ctrl_we_w, cnt_we_w, cmp_we_w;
  logic [NUM_CH-1:0]             flag_m_w, flag_o_w, rep_w, pend_w;
  logic [NUM_CH-1:0][DATA_W-1:0] cnt_w, cmp_w, ctrl_w;
  logic [BLK_W-1:0]              blk;
  logic [1:0]                    word;
  logic                          sel_start;
  logic [DATA_W-1:0]             rd_mux;
  logic                          unused_addr;

  assign blk         = bus_addr[ADDR_W-1:4];
  assign word        = bus_addr[3:2];
  assign sel_start   = (bus_addr[ADDR_W-1:2] == '0);
  assign unused_addr = ^bus_addr[1:0];

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    assign hit_ch[i]    = (blk == BLK_W'(i + 1));
    assign ctrl_we_w[i] = bus_wr & hit_ch[i] & (word == 2'd0);
    assign cnt_we_w[i]  = bus_wr & hit_ch[i] & (word == 2'd1);
    assign cmp_we_w[i]  = bus_wr & hit_ch[i] & (word == 2'd2);

    mt_channel #(.W(DATA_W), .SYNC_TICKS(SYNC_TICKS)) u_ch (
      .clk(clk), .rst(rst), .run(run_q[i]), .slow_tick(slow_tick),
      .ctrl_we(ctrl_we_w[i]), .cnt_we(cnt_we_w[i]), .cmp_we(cmp_we_w[i]),
      .wdata(bus_wdata), .ctrl_rd(ctrl_w[i]), .cnt_o(cnt_w[i]),
      .cmp_o(cmp_w[i]), .irq_o(irq_o[i]), .dma_o(dma_o[i]),
      .done_o(done_w[i]), .flag_m_o(flag_m_w[i]), .flag_o_o(flag_o_w[i]),
      .repeat_o(rep_w[i]), .pend_o(pend_w[i])
    );
  end

  // Hardware single-shot stop takes precedence over a software start.
  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= '0;
    end else begin
      run_q <= ((bus_wr && sel_start) ? bus_wdata[NUM_CH-1:0] : run_q) & ~done_w;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (sel_start) rd_mux[NUM_CH-1:0] = run_q;
    for (int i = 0; i < NUM_CH; i++) begin
      if (hit_ch[i]) begin
        case (word)
          2'd0:    rd_mux = ctrl_w[i];
          2'd1:    rd_mux = cnt_w[i];
          2'd2:    rd_mux = cmp_w[i];
          default: rd_mux = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/mt_checker.sv
module mt_checker #(
  parameter int NUM_CH = 4,
  parameter int W      = 32
) (
  input logic                   clk,
  input logic                   rst,
  input logic [NUM_CH-1:0]      run,
  input logic [NUM_CH-1:0][W-1:0] cnt,
  input logic [NUM_CH-1:0][W-1:0] cmp,
  input logic [NUM_CH-1:0]      flag_m,
  input logic [NUM_CH-1:0]      flag_o,
  input logic [NUM_CH-1:0]      rep,
  input logic [NUM_CH-1:0]      pend,
  input logic [NUM_CH-1:0]      cnt_we,
  input logic [NUM_CH-1:0]      irq,
  input logic [NUM_CH-1:0]      dma
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_a
    a_r3_stopped_holds: assert property (@(posedge clk) disable iff (rst)
      (!run[i] && !pend[i] && !cnt_we[i]) |=> $stable(cnt[i]));
    a_r5_match_source: assert property (@(posedge clk) disable iff (rst)
      $rose(flag_m[i]) |-> ($past(cnt[i] == cmp[i]) && cnt[i] == '0));
    a_r7_ovf_source: assert property (@(posedge clk) disable iff (rst)
      $rose(flag_o[i]) |-> ($past(cnt[i] == {W{1'b1}}) && cnt[i] == '0));
    a_r6_single_stops: assert property (@(posedge clk) disable iff (rst)
      ($rose(flag_m[i]) && !$past(rep[i])) |-> !run[i]);
    a_r9_one_request: assert property (@(posedge clk) disable iff (rst)
      !(irq[i] && dma[i]));
    a_r10_write_pends: assert property (@(posedge clk) disable iff (rst)
      cnt_we[i] |=> pend[i]);
  end
endmodule

bind match_timer mt_checker #(.NUM_CH(NUM_CH), .W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .run(run_q), .cnt(cnt_w), .cmp(cmp_w),
  .flag_m(flag_m_w), .flag_o(flag_o_w), .rep(rep_w), .pend(pend_w),
  .cnt_we(cnt_we_w), .irq(irq_o), .dma(dma_o)
);

// File: tb/match_timer_bench.sv
`timescale 1ns/1ps
module match_timer_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        slow_tick = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  irq_o, dma_o;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  match_timer u_match_timer (
    .clk(clk), .rst(rst), .slow_tick(slow_tick), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_o(irq_o), .dma_o(dma_o)
  );

  function automatic logic [7:0] ra(input int ch, input int w);
    return 8'(16 + ch * 16 + w * 4);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic rchk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(tag, d, exp);
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); slow_tick = 1'b1;
      @(negedge clk); slow_tick = 1'b0;
    end
    @(negedge clk);
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int codes [5];
    int divs [5];
    codes = '{0, 4, 5, 6, 7};
    divs  = '{8, 8, 32, 128, 1};
    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R1 reset state, R2 map
    rchk("R1 run reg", 8'h00, 32'h0);
    for (int i = 0; i < 4; i++) begin
      rchk("R1 ctrl", ra(i, 0), 32'h0);
      rchk("R1 count", ra(i, 1), 32'h0);
      rchk("R1 compare", ra(i, 2), 32'hFFFF_FFFF);
    end
    chk("R1 irq", {28'h0, irq_o}, 32'h0);
    chk("R1 dma", {28'h0, dma_o}, 32'h0);
    rchk("R2 unmapped high", 8'h60, 32'h0);
    rchk("R2 unmapped word3", ra(1, 3), 32'h0);
    wr(ra(2, 2), 32'h1234);
    rchk("R2 cmp ch1 untouched", ra(1, 2), 32'hFFFF_FFFF);
    rchk("R2 cmp ch2", ra(2, 2), 32'h1234);

    // R5/R9 repeat channel 0, compare 4, every tick, irq route
    wr(ra(0, 0), 32'h1A7);
    wr(ra(0, 2), 32'd4);
    wr(8'h00, 32'h1);
    ticks(4);
    rchk("R5 count before match", ra(0, 1), 32'd4);
    rchk("R5 no flag yet", ra(0, 0), 32'h1A7);
    ticks(1);
    rchk("R5 flag at period", ra(0, 0), 32'h81A7);
    rchk("R5 count wraps", ra(0, 1), 32'd0);
    chk("R9 irq raised", {28'h0, irq_o}, 32'h1);
    chk("R9 no dma on irq route", {28'h0, dma_o}, 32'h0);
    rchk("R6 repeat keeps run", 8'h00, 32'h1);
    ticks(3);
    rchk("R6 repeat counts on", ra(0, 1), 32'd3);
    wr(ra(0, 0), 32'h81A7);
    rchk("R8 write one keeps flag", ra(0, 0), 32'h81A7);
    wr(ra(0, 0), 32'h01A7);
    rchk("R8 write zero clears", ra(0, 0), 32'h1A7);
    chk("R9 irq drops", {28'h0, irq_o}, 32'h0);
    wr(ra(0, 0), 32'h81A7);
    rchk("R8 write one cannot set", ra(0, 0), 32'h1A7);

    // R6 single shot channel 1 with dma route; R3 ch0 undisturbed
    wr(ra(1, 0), 32'h97);
    wr(ra(1, 2), 32'd2);
    wr(8'h00, 32'h3);
    ticks(3);
    rchk("R6 single shot clears run bit", 8'h00, 32'h1);
    rchk("R6 single shot flag", ra(1, 0), 32'h8097);
    rchk("R6 single shot count", ra(1, 1), 32'd0);
    chk("R9 dma raised", {28'h0, dma_o}, 32'h2);
    chk("R9 irq ch0 again", {28'h0, irq_o}, 32'h1);
    rchk("R3 ch0 ran through", ra(0, 1), 32'd1);
    ticks(2);
    rchk("R3 stopped ch1 holds", ra(1, 1), 32'd0);
    rchk("R3 ch0 undisturbed", ra(0, 1), 32'd3);
    wr(8'h00, 32'h0);
    ticks(2);
    rchk("R3 stopped ch0 holds", ra(0, 1), 32'd3);
    wr(ra(0, 0), 32'h0);
    wr(ra(1, 0), 32'h0);
    rchk("R9 ctrl zero", ra(0, 0), 32'h0);
    chk("R9 irq off after zero", {28'h0, irq_o}, 32'h0);
    chk("R9 dma off after zero", {28'h0, dma_o}, 32'h0);

    // R4 prescale sweep on channel 2
    for (int s = 0; s < 5; s++) begin
      wr(ra(2, 0), 32'h100 | 32'(codes[s]));
      wr(ra(2, 2), 32'hFFFF_FFFF);
      wr(ra(2, 1), 32'h0);
      ticks(2);
      wr(8'h00, 32'h4);
      ticks(130);
      wr(8'h00, 32'h0);
      rchk("R4 prescale ratio", ra(2, 1), 32'(130 / divs[s]));
    end

    // R10 delayed count write, stopped then running
    wr(ra(3, 1), 32'h55);
    rchk("R10 old value before ticks", ra(3, 1), 32'h0);
    ticks(1);
    rchk("R10 old value after one tick", ra(3, 1), 32'h0);
    ticks(1);
    rchk("R10 loaded after two ticks", ra(3, 1), 32'h55);
    wr(ra(3, 0), 32'h107);
    wr(8'h00, 32'h8);
    ticks(2);
    rchk("R10 running", ra(3, 1), 32'h57);
    wr(ra(3, 1), 32'd100);
    ticks(1);
    rchk("R10 counts old while pending", ra(3, 1), 32'h58);
    ticks(1);
    rchk("R10 load replaces", ra(3, 1), 32'd100);
    ticks(1);
    rchk("R10 counts from loaded", ra(3, 1), 32'd101);
    wr(8'h00, 32'h0);

    // R7 overflow
    wr(ra(3, 1), 32'hFFFF_FFFE);
    ticks(2);
    wr(ra(3, 2), 32'd5);
    wr(8'h00, 32'h8);
    ticks(1);
    rchk("R7 reaches all ones", ra(3, 1), 32'hFFFF_FFFF);
    rchk("R7 no flag yet", ra(3, 0), 32'h107);
    ticks(1);
    rchk("R7 wraps to zero", ra(3, 1), 32'h0);
    rchk("R7 overflow flag", ra(3, 0), 32'h4107);
    wr(8'h00, 32'h0);
    wr(ra(3, 0), 32'h0107);
    rchk("R8 overflow cleared", ra(3, 0), 32'h107);

    // R9 route none: flag set with enable but no request
    wr(ra(3, 0), 32'h187);
    wr(ra(3, 2), 32'd0);
    wr(8'h00, 32'h8);
    ticks(1);
    rchk("R9 flag with route none", ra(3, 0), 32'h8187);
    chk("R9 route none irq", {28'h0, irq_o}, 32'h0);
    chk("R9 route none dma", {28'h0, dma_o}, 32'h0);
    wr(8'h00, 32'h0);

    // R11 read data holds
    rd(ra(2, 2), d);
    repeat (4) @(negedge clk);
    chk("R11 read data holds", bus_rdata, 32'hFFFF_FFFF);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule